// File: doc/BRIEF.md
# Codec Serial Port Frame-Sync Master

This block drives the framing side of a synchronous, full-duplex 16-bit serial link to a codec. It runs entirely from the shift clock `sclk`. It divides time into fixed periods of 256 clocks and opens a 16-clock transfer window at the start of each period by pulling the frame-sync output `fs` low. During that window one word leaves on `dout` while another word arrives on `din`, so both directions move together, bit for bit. This primary transfer carries signal samples.

Halfway through the period, at clock 128, a second 16-clock window can be opened for control traffic: a configuration word goes out and a register read-back word comes in. That window opens only when it is asked for. A request can come from the hardware pin `sec_req`, which is looked at once per period. It can also come from bit 0 of the word just received in the primary window of the same period. The parallel side offers one transmit word for each window type. Received words are handed over with a one-cycle strobe that is tagged with the window type.

Top module: `codec_fs_master`

## Requirements
- R1: Once running, successive primary frame starts (falling edges of `fs`) are exactly 256 `sclk` rising edges apart.
- R2: Every transfer window keeps `fs` low for exactly 16 cycles. `fs` returns high on the 17th rising edge, counting the edge that pulled it low as the first.
- R3: While reset is asserted, `fs` is 1 and both `dout` and `rx_valid` are 0. The first rising edge after reset is released pulls `fs` low and starts a primary window.
- R4: `dout` sends each word MSB first and changes only on rising edges. Bit 15 appears after the first edge of a window and bit 15−k after its (k+1)-th edge. The word is captured at that first edge: `pri_tx_word` for a primary window and `sec_tx_word` for a secondary one. Later changes to these inputs do not affect the word being sent.
- R5: `din` is sampled on falling edges, MSB first. After the 16th bit, `rx_word` holds the assembled word and `rx_valid` is high for exactly one cycle, which is the cycle in which `fs` returns high. In that cycle `rx_sec` is 0 for a primary word and 1 for a secondary word.
- R6: A secondary window, when opened, has its `fs` falling edge exactly 128 edges after the primary falling edge of the same period. When no request is present, `fs` stays high from cycle 16 through cycle 255 of the period.
- R7: `sec_req` is sampled only at the rising edge that would start the secondary window, which is 128 edges after the primary start. A pulse on `sec_req` at any other time has no effect.
- R8: Bit 0 (the last bit received) of the most recent primary `din` word acts as a secondary request for the same period. It is ORed with `sec_req`.
- R9: Outside transfer windows `dout` is 0 and `din` is ignored. Bits on `din` outside a window never appear in `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock; all timing is counted in its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_req | input | 1 | Hardware request for a secondary window, sampled at the secondary start edge |
| pri_tx_word | input | 16 | Word to send in the primary window |
| sec_tx_word | input | 16 | Word to send in the secondary window |
| din | input | 1 | Serial data from the codec |
| fs | output | 1 | Active-low frame sync, low during each 16-cycle window |
| dout | output | 1 | Serial data to the codec, MSB first |
| rx_word | output | 16 | Last word assembled from `din` |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |
| rx_sec | output | 1 | 1 when `rx_word` came from a secondary window |

## Verification
The bound checker watches the framing on every cycle. It checks the 256-cycle spacing of primary starts, that `fs` can fall only at cycle 0 or cycle 128 of a period, that every low stretch of `fs` lasts exactly 16 cycles, that `dout` is 0 whenever `fs` is high, and that `rx_valid` is a single-cycle pulse that lines up with the rising edge of `fs`. Other behaviour needs the bench's data. This covers the bit order of `dout` against the captured transmit words, the assembled `rx_word` values, and whether a secondary window opens for a given mix of hardware pulses and received bit-0 flags. The bench also shows that mid-window changes to the transmit inputs, and `din` activity outside the windows, leave the results untouched.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    // Which window the current (or next) cycle belongs to
    typedef struct packed {
        logic             act;  // inside a 16-cycle transfer
        logic             sec;  // the transfer is a secondary one
        logic [IDX_W-1:0] idx;  // bit slot within the transfer, 0 = MSB slot
    } slot_t;

    // Shifter state
    typedef struct packed {
        word_t tx_sh;
        word_t rx_sh;
        word_t rx_word;
        logic  dout;
        logic  rx_valid;
        logic  rx_sec;
        logic  sw_req;
    } shift_t;

endpackage

// File: rtl/cfs_slot_timer.sv
module cfs_slot_timer
    import cfs_pkg::*;
#(
    parameter int FRAME_LEN  = 256,
    parameter int SEC_OFFSET = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hw_req,
    input  logic  sw_req,
    output slot_t slot_nxt,
    output slot_t slot_cur,
    output logic  fs
);

    localparam int              CNT_W  = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] SEC_AT = CNT_W'(SEC_OFFSET);
    localparam logic [CNT_W-1:0] WIN    = CNT_W'(WORD_W);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             sec_open;
        logic             fs;
        slot_t            slot;
    } tstate_t;

    localparam tstate_t ST_RST = '{run: 1'b0, cnt: '0, sec_open: 1'b0,
                                   fs: 1'b1, slot: '0};

    tstate_t          st_d, st_q;
    logic [CNT_W-1:0] rel;
    logic             in_pri, in_sec;

    always_comb begin
        st_d = st_q;
        // period counter; the first edge after reset is cycle 0
        if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // secondary decision taken once, at the secondary start edge
        if (st_d.cnt == SEC_AT) begin
            st_d.sec_open = hw_req | sw_req;
        end else if (st_d.cnt == '0) begin
            st_d.sec_open = 1'b0;
        end
        rel    = st_d.cnt - SEC_AT;
        in_pri = st_d.cnt < WIN;
        in_sec = st_d.sec_open && (st_d.cnt >= SEC_AT) && (rel < WIN);
        st_d.slot.act = in_pri | in_sec;
        st_d.slot.sec = in_sec;
        st_d.slot.idx = in_sec ? rel[IDX_W-1:0] : st_d.cnt[IDX_W-1:0];
        st_d.fs       = !(in_pri | in_sec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_nxt = st_d.slot;
    assign slot_cur = st_q.slot;
    assign fs       = st_q.fs;

endmodule

// File: rtl/cfs_word_shifter.sv
module cfs_word_shifter
    import cfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_nxt,
    input  slot_t slot_cur,
    input  word_t pri_tx_word,
    input  word_t sec_tx_word,
    input  logic  din,
    output logic  dout,
    output word_t rx_word,
    output logic  rx_valid,
    output logic  rx_sec,
    output logic  sw_req
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    shift_t s_d, s_q;
    word_t  tx_pick;
    word_t  rx_next;
    logic   din_fall_q;

    // DIN is captured mid-bit, on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_fall_q <= 1'b0;
        end else begin
            din_fall_q <= din;
        end
    end

    always_comb begin
        s_d          = s_q;
        s_d.rx_valid = 1'b0;
        tx_pick      = slot_nxt.sec ? sec_tx_word : pri_tx_word;
        rx_next      = {s_q.rx_sh[WORD_W-2:0], din_fall_q};

        // transmit: load at first slot, then shift MSB first
        if (slot_nxt.act) begin
            if (slot_nxt.idx == '0) begin
                s_d.dout  = tx_pick[WORD_W-1];
                s_d.tx_sh = {tx_pick[WORD_W-2:0], 1'b0};
            end else begin
                s_d.dout  = s_q.tx_sh[WORD_W-1];
                s_d.tx_sh = {s_q.tx_sh[WORD_W-2:0], 1'b0};
            end
        end else begin
            s_d.dout = 1'b0;
        end

        // receive: shift the bit sampled during the slot just ending
        if (slot_cur.act) begin
            s_d.rx_sh = rx_next;
            if (slot_cur.idx == LAST_IDX) begin
                s_d.rx_word  = rx_next;
                s_d.rx_valid = 1'b1;
                s_d.rx_sec   = slot_cur.sec;
                if (!slot_cur.sec) begin
                    s_d.sw_req = din_fall_q;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout     = s_q.dout;
    assign rx_word  = s_q.rx_word;
    assign rx_valid = s_q.rx_valid;
    assign rx_sec   = s_q.rx_sec;
    assign sw_req   = s_q.sw_req;

endmodule

// File: rtl/codec_fs_master.sv
module codec_fs_master
    import cfs_pkg::*;
#(
    parameter int FRAME_LEN  = 256,
    parameter int SEC_OFFSET = 128
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sec_req,
    input  logic [WORD_W-1:0] pri_tx_word,
    input  logic [WORD_W-1:0] sec_tx_word,
    input  logic              din,
    output logic              fs,
    output logic              dout,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_sec
);

    slot_t slot_nxt;
    slot_t slot_cur;
    logic  sw_req;

    cfs_slot_timer #(
        .FRAME_LEN (FRAME_LEN),
        .SEC_OFFSET(SEC_OFFSET)
    ) timer_i (
        .clk     (sclk),
        .rst_n   (rst_n),
        .hw_req  (sec_req),
        .sw_req  (sw_req),
        .slot_nxt(slot_nxt),
        .slot_cur(slot_cur),
        .fs      (fs)
    );

    cfs_word_shifter shifter_i (
        .clk        (sclk),
        .rst_n      (rst_n),
        .slot_nxt   (slot_nxt),
        .slot_cur   (slot_cur),
        .pri_tx_word(pri_tx_word),
        .sec_tx_word(sec_tx_word),
        .din        (din),
        .dout       (dout),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid),
        .rx_sec     (rx_sec),
        .sw_req     (sw_req)
    );

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int FRAME_LEN  = 256,
    parameter int SEC_OFFSET = 128,
    parameter int WORD_W     = 16
) (
    input logic sclk,
    input logic rst_n,
    input logic fs,
    input logic dout,
    input logic rx_valid
);

    localparam int POS_W = $clog2(FRAME_LEN);
    localparam int RUN_W = $clog2(FRAME_LEN) + 1;

    logic             fs_prev_q;
    logic             started_q;
    logic [POS_W-1:0] pos_q;
    logic [RUN_W-1:0] low_run_q;

    // pos_q follows the cycle index within the period once the first fall is seen
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev_q <= 1'b1;
            started_q <= 1'b0;
            pos_q     <= '0;
            low_run_q <= '0;
        end else begin
            fs_prev_q <= fs;
            low_run_q <= fs ? '0 : low_run_q + 1'b1;
            if (started_q) begin
                pos_q <= (pos_q == POS_W'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
            end else if (fs_prev_q && !fs) begin
                started_q <= 1'b1;
                pos_q     <= POS_W'(1);
            end
        end
    end

    p_period_r1: assert property (@(posedge sclk) disable iff (!rst_n)
        (started_q && pos_q == '0) |-> $fell(fs));

    p_fall_slot_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (started_q && $fell(fs)) |-> (pos_q == '0 || pos_q == POS_W'(SEC_OFFSET)));

    p_low_len_r2: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(fs) |-> (low_run_q == RUN_W'(WORD_W)));

    p_idle_dout_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        fs |-> !dout);

    p_valid_align_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        rx_valid |-> $rose(fs));

    p_valid_every_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(fs) |-> rx_valid);

    p_valid_pulse_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind codec_fs_master cfs_checker #(
    .FRAME_LEN (FRAME_LEN),
    .SEC_OFFSET(SEC_OFFSET),
    .WORD_W    (cfs_pkg::WORD_W)
) chk_i (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .fs      (fs),
    .dout    (dout),
    .rx_valid(rx_valid)
);

// File: tb/codec_fs_master_tb_top.sv
module codec_fs_master_tb_top;

    localparam int CLK_P  = 10;
    localparam int NFRM   = 8;
    localparam int PERIOD = 256;
    localparam int SEC_AT = 128;

    logic        sclk = 1'b0;
    logic        rst_n;
    logic        sec_req;
    logic [15:0] pri_tx_word;
    logic [15:0] sec_tx_word;
    logic        din;
    logic        fs;
    logic        dout;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic        rx_sec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) sclk = ~sclk;

    codec_fs_master dut_i (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .sec_req    (sec_req),
        .pri_tx_word(pri_tx_word),
        .sec_tx_word(sec_tx_word),
        .din        (din),
        .fs         (fs),
        .dout       (dout),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid),
        .rx_sec     (rx_sec)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ptx, stx, pin, sin;
        logic        hw, sec, in_sec, exp_fs, exp_do, exp_v;

        rst_n = 1'b0; sec_req = 1'b0; din = 1'b1;
        pri_tx_word = 16'hFFFF; sec_tx_word = 16'hFFFF;
        repeat (3) @(posedge sclk);
        #(CLK_P/4);
        chk("R3 reset fs", {15'd0, fs}, 16'd1);
        chk("R3 reset dout", {15'd0, dout}, 16'd0);
        chk("R3 reset rx_valid", {15'd0, rx_valid}, 16'd0);

        for (int f = 0; f < NFRM; f++) begin
            ptx = 16'hA5C3 ^ (16'(f) * 16'h1357);
            stx = 16'h3C96 + 16'(f) * 16'h0811;
            pin = ((16'h0F0E + 16'(f) * 16'h2468) & 16'hFFFE) | {15'd0, (f % 3) == 2};
            sin = 16'hC001 ^ (16'(f) * 16'h0505);
            hw  = (f % 4) == 1;
            sec = hw | pin[0];          // R8: bit 0 of this period's primary word
            pri_tx_word = ptx;
            sec_tx_word = stx;
            if (f == 0) begin
                @(negedge sclk);
                rst_n = 1'b1;           // R3: next rising edge starts frame 0
            end
            for (int p = 0; p < PERIOD; p++) begin
                @(posedge sclk);
                #(CLK_P/4);
                in_sec = sec && p >= SEC_AT && p < SEC_AT + 16;
                exp_fs = !((p < 16) || in_sec);
                if (p < 16)      exp_do = ptx[15 - p];
                else if (in_sec) exp_do = stx[15 - (p - SEC_AT)];
                else             exp_do = 1'b0;
                exp_v = (p == 16) || (sec && p == SEC_AT + 16);
                chk("R1 R2 R6 fs", {15'd0, fs}, {15'd0, exp_fs});
                chk("R4 R9 dout", {15'd0, dout}, {15'd0, exp_do});
                chk("R5 rx_valid", {15'd0, rx_valid}, {15'd0, exp_v});
                if (p == 16) begin
                    chk("R5 R9 primary rx_word", rx_word, pin);
                    chk("R5 primary rx_sec", {15'd0, rx_sec}, 16'd0);
                end
                if (sec && p == SEC_AT + 16) begin
                    chk("R5 R6 secondary rx_word", rx_word, sin);
                    chk("R5 secondary rx_sec", {15'd0, rx_sec}, 16'd1);
                end
                // R4: changing the transmit inputs mid-window has no effect
                if (p == 5)          pri_tx_word = ~ptx;
                if (p == SEC_AT + 5) sec_tx_word = ~stx;
                // R9: junk on din outside windows
                if (p < 16)      din = pin[15 - p];
                else if (in_sec) din = sin[15 - (p - SEC_AT)];
                else             din = ~p[0];
                // R7: request sampled only at the secondary start edge
                if (p == 100)      sec_req = hw;
                else if (p == 130) sec_req = 1'b0;
                else if (p == 200) sec_req = 1'b1;
                else if (p == 250) sec_req = 1'b0;
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule